// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of recent page translations. It sits between the address path and a page table walker. Each lookup presents a virtual page number. The block compares it against the tag of every valid entry. On a match it returns the stored physical page number and the entry's flag bits in the same cycle, and no walk is started. On a mismatch it raises a walk request. The walker later hands the fetched translation back through the refill port.

A refill goes into one entry, chosen in this order:
- an entry that already holds the same tag is rewritten in place, so a tag is never held twice;
- otherwise the lowest-numbered free entry is used;
- otherwise the entry under a round-robin victim pointer is replaced.

A flush empties the whole buffer in one cycle. It is meant for task switches, where the new task reuses the same virtual addresses under different mappings. The flag field is stored and returned without being interpreted.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the victim pointer is at entry 0.
- R2: When `lk_valid` is 1 and `lk_vpn` equals the tag of a valid entry, in the same cycle `lk_hit` is 1, `walk_req` is 0, and `lk_ppn`/`lk_flags` carry that entry's stored values.
- R3: When `lk_valid` is 1 and no valid entry matches, `walk_req` is 1 and `lk_hit` is 0. When `lk_valid` is 0, both outputs are 0. `lk_ppn` and `lk_flags` are 0 whenever `lk_hit` is 0.
- R4: A refill (`fill_valid` = 1) is written at the clock edge and is visible to lookups from the next cycle. A lookup in the same cycle as the refill sees the earlier contents.
- R5: A refill whose tag is not already held goes to the lowest-numbered invalid entry, when one exists.
- R6: When all entries are valid and the refill tag is not held, the entry indexed by the victim pointer is replaced. The pointer then advances by one and wraps from the last entry to 0. It moves on no other event.
- R7: A refill whose tag equals a valid entry's tag overwrites that entry in place. No second copy is made and the victim pointer does not move.
- R8: `flush` = 1 clears every valid bit at the edge. A refill in the same cycle is discarded. The victim pointer keeps its value.
- R9: A lookup in a cycle where `flush` is 1 reports a miss (`walk_req` = 1, `lk_hit` = 0).
- R10: The 12-bit flag field of a refill is returned bit for bit on a later hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | 20 | Physical page number of the matching entry |
| lk_flags | output | 12 | Flag bits of the matching entry |
| walk_req | output | 1 | Lookup missed; a table walk is needed |
| fill_valid | input | 1 | Refill entry offered this cycle |
| fill_vpn | input | 20 | Tag of the refill entry |
| fill_ppn | input | 20 | Physical page number of the refill entry |
| fill_flags | input | 12 | Flag bits of the refill entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer completely and then forces evictions. A wrong victim choice, or a pointer that moves on the wrong event, shows up as the wrong old page missing afterwards. It refills a tag that is already held. A design without the in-place rule would keep a stale copy, or evict an innocent entry on the next replacement. It issues a lookup and a refill together with a flush. A design that lets the flush lose to the refill, or reports a hit during the flush cycle, returns a translation that should be gone. It also looks up a tag in the very cycle of its refill. A design that bypasses the write would report a hit one cycle too early. A long pseudo-random run over a small tag space then mixes hits, duplicate refills and rare flushes against a reference model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Where a committed refill lands.
  typedef enum logic [1:0] {
    PLACE_HIT_SLOT    = 2'd0,  // tag already held: rewrite in place
    PLACE_FREE_SLOT   = 2'd1,  // lowest invalid entry
    PLACE_VICTIM_SLOT = 2'd2   // round-robin replacement
  } place_kind_e;

endpackage

// File: rtl/xlat_cam.sv
// Entry storage with two parallel tag comparators (lookup and refill).
module xlat_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FLAG_W  = 12,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_tag,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [FLAG_W-1:0]  wr_flags,
  input  logic [VPN_W-1:0]   lk_tag,
  input  logic [VPN_W-1:0]   fill_tag,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fill_match,
  output logic [PPN_W-1:0]   rd_ppn,
  output logic [FLAG_W-1:0]  rd_flags
);

  logic [VPN_W-1:0]  tag_q  [ENTRIES];
  logic [PPN_W-1:0]  ppn_q  [ENTRIES];
  logic [FLAG_W-1:0] flag_q [ENTRIES];

  // A slot only matches while it is valid.
  function automatic logic slot_match(input logic vld,
                                      input logic [VPN_W-1:0] stored,
                                      input logic [VPN_W-1:0] probe);
    return vld && (stored == probe);
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tag_q[g]     <= '0;
        ppn_q[g]     <= '0;
        flag_q[g]    <= '0;
      end else if (clear_all) begin
        valid_vec[g] <= 1'b0;
      end else if (sel) begin
        valid_vec[g] <= 1'b1;
        tag_q[g]     <= wr_tag;
        ppn_q[g]     <= wr_ppn;
        flag_q[g]    <= wr_flags;
      end
    end

    assign lk_match[g]   = slot_match(valid_vec[g], tag_q[g], lk_tag);
    assign fill_match[g] = slot_match(valid_vec[g], tag_q[g], fill_tag);
  end

  // At most one slot matches, so an OR-reduction acts as the read mux.
  always_comb begin
    rd_ppn   = '0;
    rd_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        rd_ppn   = rd_ppn | ppn_q[i];
        rd_flags = rd_flags | flag_q[i];
      end
    end
  end

endmodule

// File: rtl/xlat_victim.sv
// Picks the slot a refill writes and keeps the round-robin pointer.
module xlat_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_commit,
  input  logic [ENTRIES-1:0]     valid_vec,
  input  logic [ENTRIES-1:0]     fill_match,
  output logic [IDX_W-1:0]       place_idx,
  output xlat_pkg::place_kind_e  place_kind,
  output logic [IDX_W-1:0]       rr_ptr,
  output logic                   evict_fire
);
  import xlat_pkg::*;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] rr_advance(input logic [IDX_W-1:0] p);
    if (p == IDX_W'(ENTRIES - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    if (|fill_match) begin
      place_kind = PLACE_HIT_SLOT;
      place_idx  = lowest_set(fill_match);
    end else if (!(&valid_vec)) begin
      place_kind = PLACE_FREE_SLOT;
      place_idx  = lowest_set(~valid_vec);
    end else begin
      place_kind = PLACE_VICTIM_SLOT;
      place_idx  = rr_ptr;
    end
  end

  assign evict_fire = fill_commit && (place_kind == PLACE_VICTIM_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n)          rr_ptr <= '0;
    else if (evict_fire) rr_ptr <= rr_advance(rr_ptr);
  end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FLAG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [FLAG_W-1:0] lk_flags,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [FLAG_W-1:0] fill_flags,
  input  logic              flush
);
  import xlat_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Named internal events, also used by the bound checker.
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [PPN_W-1:0]   rd_ppn;
  logic [FLAG_W-1:0]  rd_flags;
  logic               fill_commit;
  logic [IDX_W-1:0]   place_idx;
  place_kind_e        place_kind;
  logic [IDX_W-1:0]   rr_ptr;
  logic               evict_fire;
  logic               hit_int;

  // A flush wins over a refill in the same cycle.
  assign fill_commit = fill_valid && !flush;

  xlat_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .FLAG_W(FLAG_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (flush),
    .wr_en     (fill_commit),
    .wr_idx    (place_idx),
    .wr_tag    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .wr_flags  (fill_flags),
    .lk_tag    (lk_vpn),
    .fill_tag  (fill_vpn),
    .valid_vec (valid_vec),
    .lk_match  (lk_match),
    .fill_match(fill_match),
    .rd_ppn    (rd_ppn),
    .rd_flags  (rd_flags)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_commit(fill_commit),
    .valid_vec  (valid_vec),
    .fill_match (fill_match),
    .place_idx  (place_idx),
    .place_kind (place_kind),
    .rr_ptr     (rr_ptr),
    .evict_fire (evict_fire)
  );

  // A lookup during a flush is treated as a miss.
  assign hit_int  = lk_valid && !flush && (|lk_match);
  assign lk_hit   = hit_int;
  assign walk_req = lk_valid && !hit_int;
  assign lk_ppn   = hit_int ? rd_ppn   : '0;
  assign lk_flags = hit_int ? rd_flags : '0;

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FLAG_W  = 12,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic [FLAG_W-1:0]  lk_flags,
  input logic               walk_req,
  input logic               fill_valid,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [PPN_W-1:0]   fill_ppn,
  input logic [FLAG_W-1:0]  fill_flags,
  input logic               flush,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lk_match,
  input logic [IDX_W-1:0]   rr_ptr,
  input logic               evict_fire
);

  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && !walk_req));

  assert_miss_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && lk_flags == '0));

  assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_valid && !flush) && lk_valid && !flush &&
     lk_vpn == $past(fill_vpn))
    |-> (lk_hit && lk_ppn == $past(fill_ppn) && lk_flags == $past(fill_flags)));

  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evict_fire |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ?
                               IDX_W'(0) : $past(rr_ptr) + 1'b1)));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_fire |=> $stable(rr_ptr));

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  assert_flush_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lk_valid) |-> (walk_req && !lk_hit));

endmodule

bind xlat_buffer xlat_buffer_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
  .FLAG_W(FLAG_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_flags(lk_flags), .walk_req(walk_req),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .fill_flags(fill_flags), .flush(flush), .valid_vec(valid_vec),
  .lk_match(lk_match), .rr_ptr(rr_ptr), .evict_fire(evict_fire)
);

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [11:0] lk_flags;
  logic        walk_req;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [11:0] fill_flags = '0;
  logic        flush = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_flags(lk_flags), .walk_req(walk_req),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_flags(fill_flags), .flush(flush)
  );

  typedef struct {
    string       tag;
    logic        hit;
    logic        walk;
    logic [19:0] ppn;
    logic [11:0] flg;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference model built from the requirements.
  bit          m_v   [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_ppn [N];
  logic [11:0] m_flg [N];
  int          m_ptr = 0;

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  // Driver: applies one cycle of stimulus, pushes the expectation, updates the model.
  task automatic drive(input bit lv, input logic [19:0] lvpn,
                       input bit fv, input logic [19:0] fvpn,
                       input logic [19:0] fppn, input logic [11:0] fflg,
                       input bit fl, input string tag);
    exp_t e;
    int   k;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_flags = fflg;
    flush = fl;
    k = m_find(lvpn);
    e.tag  = tag;
    e.hit  = lv && !fl && (k >= 0);
    e.walk = lv && !e.hit;
    e.ppn  = e.hit ? m_ppn[k] : '0;
    e.flg  = e.hit ? m_flg[k] : '0;
    exp_q.push_back(e);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;        // R8
    end else if (fv) begin
      k = m_find(fvpn);                                   // R7
      if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;  // R5
      if (k < 0) begin                                    // R6
        k = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[k] = 1'b1; m_tag[k] = fvpn; m_ppn[k] = fppn; m_flg[k] = fflg;
    end
  endtask

  task automatic look(input logic [19:0] v, input string tag);
    drive(1'b1, v, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic [11:0] f, input string tag);
    drive(1'b0, '0, 1'b1, v, p, f, 1'b0, tag);
  endtask

  // Monitor: compares outputs a little after the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (lk_hit !== e.hit || walk_req !== e.walk ||
            lk_ppn !== e.ppn || lk_flags !== e.flg) begin
          n_bad++;
          $display("FAIL %s: hit=%b walk=%b ppn=%h flags=%h, expected hit=%b walk=%b ppn=%h flags=%h",
                   e.tag, lk_hit, walk_req, lk_ppn, lk_flags,
                   e.hit, e.walk, e.ppn, e.flg);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_ppn[i] = '0; m_flg[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(20'h00005, "R1");
    look(20'h00000, "R1");
    // R3: idle cycle raises nothing
    drive(1'b0, 20'h00005, 1'b0, '0, '0, '0, 1'b0, "R3");

    // R4: same-cycle lookup sees old contents, next cycle hits
    drive(1'b1, 20'h00010, 1'b1, 20'h00010, 20'hA0010, 12'h5A3, 1'b0, "R4");
    look(20'h00010, "R4");
    look(20'h00011, "R3");

    // R5: fill the remaining slots in order
    for (int i = 1; i < N; i++)
      fill(20'h00010 + 20'(i), 20'hA0010 + 20'(i), 12'(i * 291), "R5");
    for (int i = 0; i < N; i++) look(20'h00010 + 20'(i), "R5");

    // R6: full buffer, replacement at the pointer (entry 0)
    fill(20'h00020, 20'hB0020, 12'hFFF, "R6");
    look(20'h00010, "R6");
    look(20'h00020, "R6");
    look(20'h00011, "R6");

    // R7: refill of a held tag rewrites in place, pointer stays
    fill(20'h00012, 20'hC0012, 12'h801, "R7");
    look(20'h00012, "R7");
    fill(20'h00021, 20'hB0021, 12'h001, "R7");
    look(20'h00011, "R7");
    look(20'h00012, "R7");
    look(20'h00021, "R7");

    // R10: flag patterns returned verbatim
    fill(20'h00013, 20'hD0013, 12'hA5F, "R10");
    look(20'h00013, "R10");
    fill(20'h00013, 20'hD0013, 12'h000, "R10");
    look(20'h00013, "R10");

    // R8/R9: flush with refill and lookup in the same cycle
    drive(1'b1, 20'h00012, 1'b1, 20'h00030, 20'hE0030, 12'h111, 1'b1, "R9");
    look(20'h00030, "R8");
    look(20'h00012, "R8");
    look(20'h00020, "R8");

    // R5 after flush, then R6 with the pointer kept across the flush
    for (int i = 0; i < N; i++)
      fill(20'h00040 + 20'(i), 20'hF0040 + 20'(i), 12'(i + 7), "R5");
    fill(20'h00050, 20'hF0050, 12'h3C3, "R6");
    fill(20'h00051, 20'hF0051, 12'h3C4, "R6");
    for (int i = 0; i < N; i++) look(20'h00040 + 20'(i), "R6");
    look(20'h00050, "R6");
    look(20'h00051, "R6");

    // Pseudo-random mix over a small tag space
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      bit lv;
      bit fv;
      bit fl;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lv = lfsr[0] | lfsr[7];
      fv = lfsr[5] & lfsr[6];
      fl = (lfsr[12:8] == 5'd0);
      drive(lv, 20'h00100 + 20'(lfsr[4:1]), fv, 20'h00100 + 20'(lfsr[11:8]),
            {4'h9, lfsr}, {lfsr[15:12], lfsr[7:0]}, fl,
            fl ? "R9" : (fv ? "R7" : "R2"));
    end

    drive(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule